// File: doc/BRIEF.md
# RMS Measurement Channel with AC Offset Calibration

This block turns a stream of signed, already filtered samples from one measurement channel into a root-mean-square magnitude. Each sample is first corrected for a static offset and then scaled by a fixed-point gain. The corrected value is squared, and a stored AC offset term is taken away from that square. The squares are summed over a programmable number of samples. The sum is then divided by that count, and a sequential integer square root turns the mean into the RMS result. The same block serves a voltage channel or a current channel, one instance for each.

A calibration command removes the residual noise floor. The host grounds the channel input and issues the command. The block throws away any partly collected block and any samples still in its pipeline. It then waits for the first complete RMS result, squares that result and stores it as the AC offset, so that later squares have the floor taken out. A separate gain calibration engine tells the block when it is active. An offset calibration command received during that time is refused.

Top module: `rms_cal_channel`

## Requirements
- R1: After reset, the gain register reads 1.0 (bit GAIN_FRAC set, all other bits clear). The DC offset register, the AC offset register and the RMS result all read 0, and cal_busy and rms_done are low.
- R2: The corrected sample is y = floor(((sample + dc_offset) * gain) / 2^GAIN_FRAC). Sample and offset are two's complement, gain is unsigned, and the offset is added before the gain is applied.
- R3: A y outside the SAMPLE_W-bit signed range saturates to the most positive value or the most negative value.
- R4: Each sample contributes max(y*y - ac_offset, 0) to the accumulated sum. The difference never wraps below zero.
- R5: After n_samples accepted samples, the mean is floor(sum / n_samples). An n_samples of 0 acts as 1.
- R6: rms_value becomes floor(sqrt(mean)). rms_done is high for exactly one cycle, and that cycle is the one in which the new rms_value first appears.
- R7: An accepted calibration command raises cal_busy in the next cycle and discards the partial block and every sample already in flight. The result it captures comes from the first block made only of samples given after the command.
- R8: When that result is published, the AC offset register takes rms_value squared and cal_busy drops, both in the same cycle as rms_done.
- R9: A calibration command given while gain_cal_active is high, or while cal_busy is high, is refused. cal_rej pulses in the next cycle, and neither the calibration state nor the AC offset changes.
- R10: A write to the gain register or the DC offset register shows on its readback port in the next cycle, and applies to every sample accepted after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Two's-complement filtered sample |
| n_samples | input | CNT_W | Samples per RMS block (0 acts as 1) |
| gain_wr | input | 1 | Gain register write strobe |
| gain_wdata | input | GAIN_FRAC+1 | Unsigned gain, 1.0 = 2^GAIN_FRAC |
| dcoff_wr | input | 1 | DC offset register write strobe |
| dcoff_wdata | input | SAMPLE_W | Two's-complement DC offset |
| cal_cmd | input | 1 | Start AC offset calibration (one-cycle pulse) |
| gain_cal_active | input | 1 | A gain calibration is running elsewhere |
| cal_busy | output | 1 | AC offset calibration in progress |
| cal_rej | output | 1 | Calibration command refused (pulse) |
| rms_value | output | SAMPLE_W | Latest RMS result |
| rms_done | output | 1 | Pulse when rms_value updates |
| gain_reg | output | GAIN_FRAC+1 | Gain register readback |
| dcoff_reg | output | SAMPLE_W | DC offset register readback |
| acoff_reg | output | 2*SAMPLE_W | AC offset register (squared RMS floor) |

## Verification
The bench builds the block with SAMPLE_W=8, GAIN_FRAC=6 and CNT_W=4. At that size every 8-bit sample value can be run through single-sample blocks, and a sweep over gain and DC offset reaches both saturation rails and the floor rounding of negative products. Blocks of up to 15 samples exercise the floor of the division. The calibration runs use a DC offset as the residual floor, which makes the clamp at zero and the discard of a partial block visible in rms_value and acoff_reg.

// File: rtl/rms_cal_pkg.sv
package rms_cal_pkg;

   typedef enum logic {
      CAL_IDLE = 1'b0,
      CAL_WAIT = 1'b1
   } cal_state_t;

endpackage

// File: rtl/rms_front.sv
module rms_front #(
   parameter int SW      = 24,
   parameter int GF      = 22,
   parameter bit PIPE_SQ = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                in_valid,
   input  logic [SW-1:0]       in_sample,
   input  logic [SW-1:0]       dcoff,
   input  logic [GF:0]         gain,
   input  logic [2*SW-1:0]     acoff,
   output logic                out_valid,
   output logic [2*SW-1:0]     out_val
);
   localparam int GW   = GF + 1;
   localparam int XW   = SW + 1;
   localparam int PW   = XW + GW + 1;
   localparam int SQ_W = 2 * SW;

   generate
      if (SW < 4 || SW > 32) begin : g_bad_sw
         $error("rms_front: SW out of range");
      end
      if (GF < 1 || GF > 30) begin : g_bad_gf
         $error("rms_front: GF out of range");
      end
   endgenerate

   // stage 1: offset add
   logic          v1;
   logic [XW-1:0] x_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1  <= 1'b0;
         x_q <= '0;
      end else begin
         v1 <= in_valid & ~flush;
         if (in_valid) begin
            x_q <= {in_sample[SW-1], in_sample} + {dcoff[SW-1], dcoff};
         end
      end
   end

   // stage 2: gain multiply, floor shift, saturation
   logic signed [PW-1:0] xe, ge, prod, shifted;
   logic [PW-SW:0]       hi;
   logic                 fits;
   logic [SW-1:0]        y_next;

   always_comb begin
      xe      = $signed({{(PW-XW){x_q[XW-1]}}, x_q});
      ge      = $signed({{(PW-GW){1'b0}}, gain});
      prod    = xe * ge;
      shifted = prod >>> GF;
      hi      = shifted[PW-1:SW-1];
      fits    = (&hi) | ~(|hi);
      if (fits) begin
         y_next = shifted[SW-1:0];
      end else if (shifted[PW-1]) begin
         y_next = {1'b1, {(SW-1){1'b0}}};
      end else begin
         y_next = {1'b0, {(SW-1){1'b1}}};
      end
   end

   logic          v2;
   logic [SW-1:0] y_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2  <= 1'b0;
         y_q <= '0;
      end else begin
         v2 <= v1 & ~flush;
         if (v1) begin
            y_q <= y_next;
         end
      end
   end

   // square and AC offset removal
   logic [SW-1:0]   mag;
   logic [SQ_W-1:0] sq, diff;

   always_comb begin
      mag  = y_q[SW-1] ? (~y_q + {{(SW-1){1'b0}}, 1'b1}) : y_q;
      sq   = {{SW{1'b0}}, mag} * {{SW{1'b0}}, mag};
      diff = (sq > acoff) ? (sq - acoff) : '0;
   end

   generate
      if (PIPE_SQ) begin : g_sq_reg
         logic            v3;
         logic [SQ_W-1:0] d_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v3  <= 1'b0;
               d_q <= '0;
            end else begin
               v3 <= v2 & ~flush;
               if (v2) begin
                  d_q <= diff;
               end
            end
         end
         assign out_valid = v3;
         assign out_val   = d_q;
      end else begin : g_sq_comb
         assign out_valid = v2;
         assign out_val   = diff;
      end
   endgenerate

   AST_CLAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      v2 |-> (diff <= sq)); // R4

endmodule

// File: rtl/rms_div.sv
module rms_div #(
   parameter int DD_W = 60,
   parameter int DV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DD_W-1:0]  dividend,
   input  logic [DV_W-1:0]  divisor,
   output logic             busy,
   output logic             done,
   output logic [DD_W-1:0]  quot
);
   localparam int CW   = $clog2(DD_W + 1);
   localparam int CK_W = DD_W + DV_W + 1;

   generate
      if (DV_W < 1 || DD_W < DV_W) begin : g_bad_w
         $error("rms_div: widths inconsistent");
      end
   endgenerate

   logic [DD_W-1:0] dvd_sh, dvd_keep;
   logic [DV_W-1:0] dvs;
   logic [DV_W:0]   rem, rem_sh;
   logic [CW-1:0]   left;
   logic            ge;

   always_comb begin
      rem_sh = {rem[DV_W-1:0], dvd_sh[DD_W-1]};
      ge     = rem_sh >= {1'b0, dvs};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvd_sh   <= '0;
         dvd_keep <= '0;
         dvs      <= '0;
         rem      <= '0;
         quot     <= '0;
         left     <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            dvd_sh   <= dividend;
            dvd_keep <= dividend;
            dvs      <= divisor;
            rem      <= '0;
            quot     <= '0;
            left     <= CW'(DD_W);
            busy     <= 1'b1;
         end else if (busy) begin
            rem    <= ge ? (rem_sh - {1'b0, dvs}) : rem_sh;
            quot   <= {quot[DD_W-2:0], ge};
            dvd_sh <= {dvd_sh[DD_W-2:0], 1'b0};
            left   <= left - 1'b1;
            if (left == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   logic [CK_W-1:0] ck_lo, ck_hi, ck_n;
   always_comb begin
      ck_lo = CK_W'(quot) * CK_W'(dvs);
      ck_hi = ck_lo + CK_W'(dvs);
      ck_n  = CK_W'(dvd_keep);
   end

   AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ck_lo <= ck_n && ck_hi > ck_n)); // R5
   AST_DIV_REM: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem < {1'b0, dvs})); // R5

endmodule

// File: rtl/rms_isqrt.sv
module rms_isqrt #(
   parameter int RAD_W = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [RAD_W-1:0]     rad,
   output logic                 busy,
   output logic                 done,
   output logic [RAD_W/2-1:0]   root
);
   localparam int RT_W  = RAD_W / 2;
   localparam int REM_W = RT_W + 3;
   localparam int CW    = $clog2(RT_W + 1);
   localparam int CK_W  = RAD_W + 2;

   generate
      if (RAD_W % 2 != 0 || RAD_W < 4) begin : g_bad_w
         $error("rms_isqrt: RAD_W must be even and at least 4");
      end
   endgenerate

   logic [RAD_W-1:0] rad_sh, rad_keep;
   logic [REM_W-1:0] rem, rem_sh, trial;
   logic [CW-1:0]    left;
   logic             ge;

   always_comb begin
      rem_sh = {rem[REM_W-3:0], rad_sh[RAD_W-1 -: 2]};
      trial  = {1'b0, root, 2'b01};
      ge     = rem_sh >= trial;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rad_sh   <= '0;
         rad_keep <= '0;
         rem      <= '0;
         root     <= '0;
         left     <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rad_sh   <= rad;
            rad_keep <= rad;
            rem      <= '0;
            root     <= '0;
            left     <= CW'(RT_W);
            busy     <= 1'b1;
         end else if (busy) begin
            rem    <= ge ? (rem_sh - trial) : rem_sh;
            root   <= {root[RT_W-2:0], ge};
            rad_sh <= {rad_sh[RAD_W-3:0], 2'b00};
            left   <= left - 1'b1;
            if (left == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   logic [CK_W-1:0] r_lo, r_hi, r_n;
   always_comb begin
      r_lo = CK_W'(root) * CK_W'(root);
      r_hi = (CK_W'(root) + 1'b1) * (CK_W'(root) + 1'b1);
      r_n  = CK_W'(rad_keep);
   end

   AST_ROOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (r_lo <= r_n && r_hi > r_n)); // R6
   AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem[REM_W-1:REM_W-2] == 2'b00)); // R6

endmodule

// File: rtl/rms_cal_channel.sv
module rms_cal_channel
   import rms_cal_pkg::*;
#(
   parameter int SAMPLE_W  = 24,
   parameter int GAIN_FRAC = 22,
   parameter int CNT_W     = 12,
   parameter bit PIPE_SQ   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_valid,
   input  logic [SAMPLE_W-1:0]     smp_data,
   input  logic [CNT_W-1:0]        n_samples,
   input  logic                    gain_wr,
   input  logic [GAIN_FRAC:0]      gain_wdata,
   input  logic                    dcoff_wr,
   input  logic [SAMPLE_W-1:0]     dcoff_wdata,
   input  logic                    cal_cmd,
   input  logic                    gain_cal_active,
   output logic                    cal_busy,
   output logic                    cal_rej,
   output logic [SAMPLE_W-1:0]     rms_value,
   output logic                    rms_done,
   output logic [GAIN_FRAC:0]      gain_reg,
   output logic [SAMPLE_W-1:0]     dcoff_reg,
   output logic [2*SAMPLE_W-1:0]   acoff_reg
);
   localparam int GAIN_W = GAIN_FRAC + 1;
   localparam int SQ_W   = 2 * SAMPLE_W;
   localparam int ACC_W  = SQ_W + CNT_W;
   localparam logic [GAIN_W-1:0] GAIN_ONE = {1'b1, {GAIN_FRAC{1'b0}}};

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("rms_cal_channel: CNT_W out of range");
      end
   endgenerate

   // programmable registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_reg  <= GAIN_ONE;
         dcoff_reg <= '0;
      end else begin
         if (gain_wr)  gain_reg  <= gain_wdata;
         if (dcoff_wr) dcoff_reg <= dcoff_wdata;
      end
   end

   // calibration command decode
   cal_state_t cal_st;
   logic       cal_ok;

   assign cal_ok   = cal_cmd && (cal_st == CAL_IDLE) && !gain_cal_active;
   assign cal_busy = (cal_st == CAL_WAIT);

   // correction front end
   logic            f_valid;
   logic [SQ_W-1:0] f_val;

   rms_front #(
      .SW      (SAMPLE_W),
      .GF      (GAIN_FRAC),
      .PIPE_SQ (PIPE_SQ)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (cal_ok),
      .in_valid  (smp_valid),
      .in_sample (smp_data),
      .dcoff     (dcoff_reg),
      .gain      (gain_reg),
      .acoff     (acoff_reg),
      .out_valid (f_valid),
      .out_val   (f_val)
   );

   // block accumulation
   logic [ACC_W-1:0] acc_q, acc_sum;
   logic [CNT_W-1:0] cnt_q, eff_n;
   logic [CNT_W:0]   cnt_inc;
   logic             take, blk_end;

   always_comb begin
      eff_n   = (n_samples == '0) ? CNT_W'(1) : n_samples;
      cnt_inc = {1'b0, cnt_q} + 1'b1;
      take    = f_valid && !cal_ok;
      blk_end = take && (cnt_inc >= {1'b0, eff_n});
      acc_sum = acc_q + {{CNT_W{1'b0}}, f_val};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || cal_ok) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (blk_end) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         acc_q <= acc_sum;
         cnt_q <= cnt_inc[CNT_W-1:0];
      end
   end

   // mean and root
   logic             div_busy, div_done, sq_busy, sq_done;
   logic [ACC_W-1:0] div_q;
   logic [SAMPLE_W-1:0] root;

   rms_div #(
      .DD_W (ACC_W),
      .DV_W (CNT_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (blk_end),
      .dividend (acc_sum),
      .divisor  (eff_n),
      .busy     (div_busy),
      .done     (div_done),
      .quot     (div_q)
   );

   rms_isqrt #(
      .RAD_W (SQ_W)
   ) u_sqrt (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_done),
      .rad   (div_q[SQ_W-1:0]),
      .busy  (sq_busy),
      .done  (sq_done),
      .root  (root)
   );

   // result publish and calibration capture
   logic tag_div, tag_sq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_st    <= CAL_IDLE;
         cal_rej   <= 1'b0;
         acoff_reg <= '0;
         rms_value <= '0;
         rms_done  <= 1'b0;
         tag_div   <= 1'b0;
         tag_sq    <= 1'b0;
      end else begin
         cal_rej  <= cal_cmd && !cal_ok;
         rms_done <= sq_done;
         if (cal_ok) cal_st <= CAL_WAIT;
         if (blk_end) tag_div <= (cal_st == CAL_WAIT);
         if (div_done) tag_sq <= tag_div;
         if (sq_done) begin
            rms_value <= root;
            if (tag_sq) begin
               acoff_reg <= {{SAMPLE_W{1'b0}}, root} * {{SAMPLE_W{1'b0}}, root};
               cal_st    <= CAL_IDLE;
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rms_done |=> !rms_done); // R6
   AST_CAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cal_busy) |-> (rms_done &&
         acoff_reg == {{SAMPLE_W{1'b0}}, rms_value} * {{SAMPLE_W{1'b0}}, rms_value})); // R8
   AST_CAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_busy) |-> $past(!gain_cal_active)); // R9
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end |-> !div_busy) and (div_done |-> !sq_busy)); // R5
   AST_MEAN_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |-> (div_q[ACC_W-1:SQ_W] == '0)); // R5

endmodule

// File: tb/tb_rms_cal_channel.sv
module tb_rms_cal_channel;
   localparam int CLK_NS = 10;
   localparam int SW = 8;
   localparam int GF = 6;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic smp_valid;
   logic [SW-1:0] smp_data;
   logic [CW-1:0] n_samples;
   logic gain_wr;
   logic [GF:0] gain_wdata;
   logic dcoff_wr;
   logic [SW-1:0] dcoff_wdata;
   logic cal_cmd;
   logic gain_cal_active;
   logic cal_busy, cal_rej, rms_done;
   logic [SW-1:0] rms_value;
   logic [GF:0] gain_reg;
   logic [SW-1:0] dcoff_reg;
   logic [2*SW-1:0] acoff_reg;

   always #(CLK_NS/2) clk = ~clk;

   rms_cal_channel #(
      .SAMPLE_W (SW), .GAIN_FRAC (GF), .CNT_W (CW), .PIPE_SQ (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid), .smp_data (smp_data),
      .n_samples (n_samples), .gain_wr (gain_wr), .gain_wdata (gain_wdata),
      .dcoff_wr (dcoff_wr), .dcoff_wdata (dcoff_wdata), .cal_cmd (cal_cmd),
      .gain_cal_active (gain_cal_active), .cal_busy (cal_busy), .cal_rej (cal_rej),
      .rms_value (rms_value), .rms_done (rms_done), .gain_reg (gain_reg),
      .dcoff_reg (dcoff_reg), .acoff_reg (acoff_reg)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int cur_g, cur_dc, cur_ac;
   int blk [16];

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int isqrt(input int m);
      int r = 0;
      while ((r + 1) * (r + 1) <= m) r++;
      return r;
   endfunction

   function automatic int contrib(input int s);
      int p, y, sq;
      p = (s + cur_dc) * cur_g;
      y = p >>> GF;
      if (y > 127) y = 127;
      if (y < -128) y = -128;
      sq = y * y;
      return (sq > cur_ac) ? sq - cur_ac : 0;
   endfunction

   task automatic send(input int s);
      smp_valid = 1'b1;
      smp_data  = s[SW-1:0];
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic wait_done(output bit got);
      got = 1'b0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (rms_done) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   task automatic run_blk(input int n, input string req, output int exp_rms);
      int ne, sum;
      bit got;
      ne = (n == 0) ? 1 : n;
      n_samples = n[CW-1:0];
      sum = 0;
      for (int i = 0; i < ne; i++) begin
         send(blk[i]);
         sum += contrib(blk[i]);
      end
      wait_done(got);
      exp_rms = isqrt(sum / ne);
      check(req, got ? int'(rms_value) : -1, exp_rms);
   endtask

   task automatic set_gain(input int g);
      gain_wr = 1'b1;
      gain_wdata = g[GF:0];
      @(negedge clk);
      gain_wr = 1'b0;
      cur_g = g;
      check("R10 gain readback", int'(gain_reg), g);
   endtask

   task automatic set_dc(input int d);
      dcoff_wr = 1'b1;
      dcoff_wdata = d[SW-1:0];
      @(negedge clk);
      dcoff_wr = 1'b0;
      cur_dc = d;
      check("R10 dcoff readback", int'(dcoff_reg), d & 255);
   endtask

   task automatic pulse_cal();
      cal_cmd = 1'b1;
      @(negedge clk);
      cal_cmd = 1'b0;
   endtask

   initial begin
      int e;
      bit got;
      rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; n_samples = 4'd1;
      gain_wr = 1'b0; gain_wdata = '0; dcoff_wr = 1'b0; dcoff_wdata = '0;
      cal_cmd = 1'b0; gain_cal_active = 1'b0;
      cur_g = 64; cur_dc = 0; cur_ac = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 gain", int'(gain_reg), 64);
      check("R1 dcoff", int'(dcoff_reg), 0);
      check("R1 acoff", int'(acoff_reg), 0);
      check("R1 rms", int'(rms_value), 0);
      check("R1 busy", int'(cal_busy), 0);
      check("R1 done", int'(rms_done), 0);

      // R2 R6: every sample value, default gain and offset, N=1
      for (int s = -128; s < 128; s++) begin
         blk[0] = s;
         run_blk(1, "R2 R6 sample sweep", e);
      end
      // R6 done pulse width
      @(negedge clk);
      check("R6 done one cycle", int'(rms_done), 0);

      // R2 R3 R10: gain and offset sweep, including saturation
      for (int gi = 0; gi < 5; gi++) begin
         int gv [5] = '{0, 32, 64, 96, 127};
         set_gain(gv[gi]);
         for (int di = 0; di < 3; di++) begin
            int dv [3] = '{-20, 0, 17};
            set_dc(dv[di]);
            for (int s = -128; s < 128; s += 17) begin
               blk[0] = s;
               run_blk(1, "R2 R3 gain/offset", e);
            end
         end
      end
      set_gain(64);
      set_dc(0);

      // R5 averaging with floor, and N=0 acting as 1
      for (int i = 0; i < 15; i++) blk[i] = (i * 37) % 200 - 100;
      run_blk(15, "R5 N=15", e);
      blk[0] = 3; blk[1] = 4; blk[2] = 0; blk[3] = 1;
      run_blk(4, "R5 N=4 floor", e);
      blk[0] = -7;
      run_blk(0, "R5 N=0", e);

      // R9 refused while gain calibration active
      gain_cal_active = 1'b1;
      pulse_cal();
      check("R9 rej gain active", int'(cal_rej), 1);
      check("R9 busy stays low", int'(cal_busy), 0);
      gain_cal_active = 1'b0;
      blk[0] = 9;
      run_blk(1, "R9 no state change rms", e);
      check("R9 acoff unchanged", int'(acoff_reg), 0);

      // R7 R8 calibration with partial block discarded
      set_dc(3);
      n_samples = 4'd4;
      send(100);
      send(100);
      pulse_cal();
      check("R7 busy raised", int'(cal_busy), 1);
      check("R7 no reject", int'(cal_rej), 0);
      for (int i = 0; i < 4; i++) blk[i] = 0;
      run_blk(4, "R7 first clean block", e);
      check("R8 acoff = rms^2", int'(acoff_reg), e * e);
      check("R8 busy cleared", int'(cal_busy), 0);
      cur_ac = e * e;

      // R4 AC offset removal and clamp
      blk[0] = 0;  run_blk(1, "R4 zero after cal", e);
      blk[0] = 1;  run_blk(1, "R4 subtract", e);
      set_dc(0);
      blk[0] = 2;  run_blk(1, "R4 clamp", e);
      blk[0] = -5; run_blk(1, "R4 negative sample", e);

      // R9 refused while already busy, then R8 recalibration
      pulse_cal();
      check("R7 busy on second cal", int'(cal_busy), 1);
      pulse_cal();
      check("R9 rej while busy", int'(cal_rej), 1);
      check("R9 busy kept", int'(cal_busy), 1);
      blk[0] = 0; blk[1] = 0;
      run_blk(2, "R7 recal block", e);
      check("R8 recal acoff", int'(acoff_reg), e * e);
      check("R8 recal busy", int'(cal_busy), 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule